// File: doc/BRIEF.md
# Audio Port Interrupt Status Unit

This unit collects the event and level conditions of a full-duplex audio serial port and turns them into one interrupt line. The data path sends one-cycle pulses for nine conditions (end of transfer, transfer filled, underrun, overrun, CRC error, frame error, mode fault, transfer-size reload and suspend). Each pulse sets a sticky flag that stays set until software clears it. The data path also drives live level indications. These appear in the status word as they are and cannot be cleared.

Software reaches three registers through a small read/write port. The first is an interrupt-enable register that covers status bits 0 to 10. The second is a read-only status register. The third is a write-only clear register, where a 1 in bits 3 to 11 drops the matching sticky flag. The interrupt output is high whenever a status bit and its enable bit are both 1.

Top module: `aud_irq_stat`

## Requirements
- R1: After reset the enable register reads 0, every sticky flag is 0 and irq_o is 0.
- R2: A one-cycle pulse on evt_i[k] sets status bit k+3 from the next clock edge on. The bit then holds with no further pulse. Bit 3 is end of transfer, 4 transfer filled, 5 underrun, 6 overrun, 7 CRC error, 8 frame error, 9 mode fault, 10 reload and 11 suspended.
- R3: A write to address 2 clears every sticky status bit (3 to 11) whose write-data bit is 1 and leaves the others unchanged.
- R4: When an event pulse and a clear of the same bit fall in the same cycle, the bit is set after that edge.
- R5: Status bits 0 (rx_avail_i), 1 (tx_space_i), 2 (dup_avail_i), 12 (tx_done_i), 14:13 (rx_pack_lvl_i) and 15 (rx_word_i) follow their inputs in the same cycle. A write to the clear register has no effect on them.
- R6: The enable register sits at address 0 and stores write-data bits 10:0. Bits 15:11 always read 0.
- R7: irq_o is 1 exactly when the AND of status bits 10:0 and enable bits 10:0 is nonzero. Status bit 11 never raises it.
- R8: While an enable bit is 0, its status bit holds irq_o low even though that status bit is set.
- R9: The status register is at address 1. Writes to it change nothing. The clear register at address 2 and the unused address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 9 | One-cycle event pulses, index k maps to status bit k+3 |
| rx_avail_i | input | 1 | Live: receive packet available |
| tx_space_i | input | 1 | Live: transmit space available |
| dup_avail_i | input | 1 | Live: duplex packet available |
| tx_done_i | input | 1 | Live: transmit complete |
| rx_pack_lvl_i | input | 2 | Live: receive packing level |
| rx_word_i | input | 1 | Live: receive word not empty |
| reg_addr_i | input | 2 | Register address: 0 enable, 1 status, 2 clear |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i, same cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default build: a 16-bit register word, nine sticky flags and an 11-bit enable. These sizes are small enough to sweep fully. The bench writes all 2048 enable patterns and all 512 clear masks. It also drives all 128 combinations of the live inputs, each followed by a full clear write. Every sticky bit is walked through set, hold, masked, enabled and cleared. It is also hit by an event and a clear in the same cycle.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned IEN_W     = 11;  // enable covers status[10:0]
  localparam int unsigned STICKY_LO = 3;
  localparam int unsigned STICKY_HI = 11;
  localparam int unsigned STICKY_N  = STICKY_HI - STICKY_LO + 1;
  localparam logic [ADDR_W-1:0] A_IEN  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd2;
endpackage

// File: rtl/aud_irq_flags.sv
module aud_irq_flags #(
  parameter int unsigned N = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else         flag_q[g] <= evt_i[g] | (flag_q[g] & ~clr_i[g]);  // event wins
    end

    a_r4_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flag_q[g]);
    a_r2_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !evt_i[g]) |=> !flag_q[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/aud_irq_ctrl.sv
module aud_irq_ctrl
  import aud_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  input  logic [REG_W-1:0]    stat_i,
  output logic [IEN_W-1:0]    en_o,
  output logic [STICKY_N-1:0] clr_o,
  output logic [REG_W-1:0]    rdata_o
);
  logic [IEN_W-1:0] en_q;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata_i[REG_W-1:STICKY_HI+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              en_q <= '0;
    else if (reg_wr_i && reg_addr_i == A_IEN) en_q <= reg_wdata_i[IEN_W-1:0];
  end

  // clear strobe lasts only the write cycle
  assign clr_o = (reg_wr_i && reg_addr_i == A_CLR) ?
                 reg_wdata_i[STICKY_HI:STICKY_LO] : '0;

  always_comb begin
    unique case (reg_addr_i)
      A_IEN:   rdata_o = {{(REG_W-IEN_W){1'b0}}, en_q};
      A_STAT:  rdata_o = stat_i;
      default: rdata_o = '0;
    endcase
  end

  assign en_o = en_q;

  a_r6_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == A_IEN) |=> (en_q == $past(reg_wdata_i[IEN_W-1:0])));
  a_r6_en_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == A_IEN) |=> $stable(en_q));
endmodule

// File: rtl/aud_irq_stat.sv
module aud_irq_stat
  import aud_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [STICKY_N-1:0] evt_i,
  input  logic                rx_avail_i,
  input  logic                tx_space_i,
  input  logic                dup_avail_i,
  input  logic                tx_done_i,
  input  logic [1:0]          rx_pack_lvl_i,
  input  logic                rx_word_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic                irq_o
);
  logic [STICKY_N-1:0] flag;
  logic [STICKY_N-1:0] clr;
  logic [IEN_W-1:0]    en;
  logic [REG_W-1:0]    stat;

  aud_irq_flags #(.N(STICKY_N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr),
    .flag_o (flag)
  );

  // bit positions are fixed: software decodes them
  assign stat = {rx_word_i, rx_pack_lvl_i, tx_done_i, flag,
                 dup_avail_i, tx_space_i, rx_avail_i};

  aud_irq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .stat_i      (stat),
    .en_o        (en),
    .clr_o       (clr),
    .rdata_o     (reg_rdata_o)
  );

  assign irq_o = |(stat[IEN_W-1:0] & en);

  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
  a_r9_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CLR) |-> (reg_rdata_o == '0));
  a_r5_live_unclearable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_STAT) |-> (reg_rdata_o[2:0] == {dup_avail_i, tx_space_i, rx_avail_i}));
endmodule

// File: tb/aud_irq_stat_tb.sv
module aud_irq_stat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  evt = '0;
  logic        rx_avail = 0, tx_space = 0, dup_avail = 0, tx_done = 0, rx_word = 0;
  logic [1:0]  rx_pack_lvl = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int          nchk = 0;
  int          nerr = 0;
  logic [15:0] d;

  always #10 clk = ~clk;  // 50 MHz

  aud_irq_stat u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt),
    .rx_avail_i(rx_avail), .tx_space_i(tx_space), .dup_avail_i(dup_avail),
    .tx_done_i(tx_done), .rx_pack_lvl_i(rx_pack_lvl), .rx_word_i(rx_word),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] v);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic pulse(input logic [8:0] e);
    evt = e;
    @(posedge clk); @(negedge clk);
    evt = '0;
  endtask

  task automatic set_live(input logic [6:0] v);
    rx_avail = v[0]; tx_space = v[1]; dup_avail = v[2];
    tx_done = v[3]; rx_pack_lvl = v[5:4]; rx_word = v[6];
  endtask

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 enable", d, 16'h0);
    rd(2'd1, d); chk("R1 status", d, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);

    // R5 live bits, all combinations, then a full clear write
    for (int v = 0; v < 128; v++) begin
      logic [15:0] e;
      set_live(v[6:0]);
      e = {v[6:3], 9'd0, v[2:0]};
      rd(2'd1, d); chk("R5 live", d, e);
      wr(2'd2, 16'hFFFF);
      rd(2'd1, d); chk("R5 unclearable", d, e);
    end
    set_live('0);

    // R2 R3 R7 R8 per sticky bit
    for (int k = 0; k < 9; k++) begin
      int b;
      b = k + 3;
      pulse(9'(1 << k));
      rd(2'd1, d); chk("R2 set", d, 16'(1 << b));
      @(negedge clk);
      rd(2'd1, d); chk("R2 hold", d, 16'(1 << b));
      chk("R8 masked", {15'd0, irq}, 16'h0);
      if (b <= 10) begin
        wr(2'd0, 16'(1 << b));
        chk("R7 enabled", {15'd0, irq}, 16'h1);
        wr(2'd0, 16'h07FF & ~16'(1 << b));
        chk("R8 other enables", {15'd0, irq}, 16'h0);
      end else begin
        wr(2'd0, 16'h07FF);
        chk("R7 suspend no irq", {15'd0, irq}, 16'h0);
      end
      wr(2'd0, 16'h0);
      wr(2'd2, 16'(1 << b));
      rd(2'd1, d); chk("R3 clear one", d, 16'h0);
    end

    // R3 every clear mask
    for (int m = 0; m < 512; m++) begin
      pulse(9'h1FF);
      wr(2'd2, {4'hF, 9'(m), 3'b111});
      rd(2'd1, d); chk("R3 mask", d, {4'h0, ~9'(m), 3'b000});
      wr(2'd2, 16'hFFFF);
    end

    // R4 event and clear together, from cleared and from set
    for (int k = 0; k < 9; k++) begin
      for (int pre = 0; pre < 2; pre++) begin
        if (pre == 1) pulse(9'(1 << k));
        evt = 9'(1 << k);
        reg_addr = 2'd2; reg_wdata = 16'hFFFF; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        evt = '0; reg_wr = 1'b0;
        rd(2'd1, d); chk("R4 event wins", d, 16'(1 << (k + 3)));
        wr(2'd2, 16'hFFFF);
      end
    end

    // R6 R7 all enable patterns; status = bit0 live + bit5 underrun
    set_live(7'd1);
    pulse(9'(1 << 2));
    for (int e = 0; e < 2048; e++) begin
      wr(2'd0, 16'hF800 | 16'(e));
      rd(2'd0, d); chk("R6 enable rb", d, 16'(e));
      chk("R7 irq", {15'd0, irq}, {15'd0, (e[0] | e[5])});
    end

    // R9 status read-only, clear and spare addresses read 0
    wr(2'd1, 16'h0000);
    rd(2'd1, d); chk("R9 stat ro", d, 16'h0021);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d); chk("R9 stat ro", d, 16'h0021);
    rd(2'd2, d); chk("R9 clr reads 0", d, 16'h0);
    rd(2'd3, d); chk("R9 spare reads 0", d, 16'h0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule